// File: doc/BRIEF.md
# Word-Addressed Memory Slave for a Direct Memory Access Port

This block answers a simple direct-memory-access style request port with a 16-bit data path. A master raises a request enable together with a word address, a two-bit byte-lane write strobe and write data. It holds all of them steady until it sees the ready output high on a rising clock edge. A strobe of zero with the enable high asks for a read. Any non-zero strobe asks for a write of the lanes it selects. The slave keeps two small backing memories built from register arrays. The program window is 128 words at byte address 0xFE00. The data window is 128 words at byte address 0x0200. The slave steers each access into one of them by address.

A two-bit wait-state input stretches each access by up to three clock cycles before ready is raised. A request whose address lies in neither window still completes, but its error response is set. Read data is registered on the accepting edge, so the master picks it up in the clock period that follows. Reset is asynchronous and active low, and is released synchronously by the surrounding chip.

Top module: `dmaport_mem_slave`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `rsp_ready`, `rsp_err` and `rsp_rdata` are all zero.
- R2: The wait count N (0 to 3) is sampled on the edge that first sees a request. `rsp_ready` is first high in the (N+1)th clock period after that edge, and stays high for exactly one cycle per access.
- R3: A write with strobe 2'b11 stores all 16 bits. A later read (strobe 2'b00) of the same word returns them.
- R4: Strobe 2'b01, used for an even byte address, writes only bits 7:0 of the addressed word. Bits 15:8 are left unchanged.
- R5: Strobe 2'b10, used for an odd byte address, writes only bits 15:8 of the addressed word. Bits 7:0 are left unchanged.
- R6: Read data is valid on `rsp_rdata` in the clock period after the accepting edge, which is the edge where ready and enable are both high. The data is held there until the next accepted read.
- R7: Byte addresses 0xFE00 to 0xFEFF map to the 128 program words, and 0x0200 to 0x02FF map to the 128 data words. The first and last word of each window are usable.
- R8: A request outside both windows completes with `rsp_err` high in the same cycle as `rsp_ready`. Its write changes no word in either window. Its read returns 0x0000.
- R9: A request inside either window completes with `rsp_err` low.
- R10: The two windows hold separate storage, so the same word index in each keeps its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_en | input | 1 | Request enable, held until ready is sampled high |
| req_waddr | input | 15 | Word address (byte address bits 15:1) |
| req_strb | input | 2 | Byte-lane write strobe; 2'b00 means read |
| req_wdata | input | 16 | Write data, byte writes already placed in their lane |
| wait_cnt | input | 2 | Number of wait states inserted before ready |
| rsp_ready | output | 1 | Access completes on the edge where this is high |
| rsp_err | output | 1 | Response: 0 okay, 1 error; valid with ready |
| rsp_rdata | output | 16 | Read data, valid the cycle after the accepting edge |

## Verification
The bench targets addresses that sit just outside each window but share a word index with a stored word, such as 0xFDFE, 0xFF00 and 0x0300. A decoder that compared too few upper bits would alias these onto live words. It would then overwrite them, or return their data without flagging an error. Byte writes to odd and even addresses are read back as whole words, which catches a design that swaps the lanes or writes both. Every wait count is run with its latency counted, which exposes an off-by-one in the wait counter. Reads are followed by writes and by missed accesses to show that the read register holds its value. A reset applied in the middle of a stretched access must leave ready low.

// File: rtl/dmaport_pkg.sv
package dmaport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } acc_state_e;

  localparam logic [1:0] STRB_READ = 2'b00;

endpackage

// File: rtl/dmaport_decode.sv
module dmaport_decode #(
  parameter int AW      = 15,
  parameter int IDX_W   = 7,
  parameter int NWIN    = 2,
  parameter logic [NWIN*AW-1:0] WIN_BASE = '0
) (
  input  logic [AW-1:0]    waddr,
  output logic [NWIN-1:0]  win_hit,
  output logic [IDX_W-1:0] idx,
  output logic             miss
);

  localparam int TAG_W = AW - IDX_W;

  assign idx = waddr[IDX_W-1:0];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [AW-1:0] BASE_W = WIN_BASE[w*AW +: AW];
    assign win_hit[w] = (waddr[AW-1:IDX_W] == BASE_W[AW-1:IDX_W]);
  end

  assign miss = ~|win_hit;

  logic [TAG_W-1:0] unused_tag_chk;
  assign unused_tag_chk = '0;

endmodule

// File: rtl/dmaport_bank.sv
module dmaport_bank #(
  parameter int DW    = 16,
  parameter int WORDS = 128,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [DW/8-1:0]      strb,
  input  logic [IDX_W-1:0]     idx,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata
);

  localparam int LANES = DW / 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    logic       lane_we;

    assign lane_we = wr_en & strb[l];

    always_ff @(posedge clk) begin
      if (lane_we) begin
        lane_mem[idx] <= wdata[l*8 +: 8];
      end
    end

    assign rdata[l*8 +: 8] = lane_mem[idx];
  end

endmodule

// File: rtl/dmaport_ctrl.sv
module dmaport_ctrl
  import dmaport_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_en,
  input  logic [WAIT_W-1:0] wait_cnt,
  input  logic              miss,
  output logic              ready,
  output logic              err,
  output logic              accept
);

  acc_state_e        st_q, st_n;
  logic [WAIT_W-1:0] cnt_q, cnt_n;
  logic              rdy_q, rdy_n;
  logic              err_q, err_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    rdy_n = 1'b0;
    err_n = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_en) begin
          if (wait_cnt == '0) begin
            st_n  = ST_DONE;
            rdy_n = 1'b1;
            err_n = miss;
          end else begin
            st_n  = ST_WAIT;
            cnt_n = wait_cnt;
          end
        end
      end
      ST_WAIT: begin
        if (cnt_q == WAIT_W'(1)) begin
          st_n  = ST_DONE;
          rdy_n = 1'b1;
          err_n = miss;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q - WAIT_W'(1);
        end
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rdy_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      rdy_q <= rdy_n;
      err_q <= err_n;
    end
  end

  assign ready  = rdy_q;
  assign err    = err_q;
  assign accept = rdy_q & req_en;

endmodule

// File: rtl/dmaport_mem_slave.sv
module dmaport_mem_slave
  import dmaport_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          WORDS     = 128,
  parameter int          WAIT_W    = 2,
  parameter logic [15:0] PROG_BASE = 16'hFE00,
  parameter logic [15:0] DATA_BASE = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_en,
  input  logic [14:0]       req_waddr,
  input  logic [1:0]        req_strb,
  input  logic [DW-1:0]     req_wdata,
  input  logic [WAIT_W-1:0] wait_cnt,
  output logic              rsp_ready,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata
);

  localparam int AW    = 15;
  localparam int IDX_W = $clog2(WORDS);
  localparam int NWIN  = 2;
  localparam int LANES = DW / 8;
  localparam logic [AW-1:0] PROG_W = PROG_BASE[AW:1];
  localparam logic [AW-1:0] DATA_W = DATA_BASE[AW:1];
  localparam logic [NWIN*AW-1:0] BASES = {DATA_W, PROG_W};

  logic [NWIN-1:0]  win_hit;
  logic [IDX_W-1:0] idx;
  logic             miss;
  logic             accept;
  logic             wr_acc, rd_acc;
  logic [DW-1:0]    bank_rd [NWIN];
  logic [DW-1:0]    rd_mux;
  logic [DW-1:0]    rdata_q, rdata_n;

  dmaport_decode #(
    .AW(AW), .IDX_W(IDX_W), .NWIN(NWIN), .WIN_BASE(BASES)
  ) u_decode (
    .waddr   (req_waddr),
    .win_hit (win_hit),
    .idx     (idx),
    .miss    (miss)
  );

  dmaport_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_en   (req_en),
    .wait_cnt (wait_cnt),
    .miss     (miss),
    .ready    (rsp_ready),
    .err      (rsp_err),
    .accept   (accept)
  );

  assign wr_acc = accept & (req_strb != STRB_READ);
  assign rd_acc = accept & (req_strb == STRB_READ);

  for (genvar w = 0; w < NWIN; w++) begin : g_bank
    dmaport_bank #(.DW(DW), .WORDS(WORDS), .IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .wr_en (wr_acc & win_hit[w]),
      .strb  (req_strb[LANES-1:0]),
      .idx   (idx),
      .wdata (req_wdata),
      .rdata (bank_rd[w])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (win_hit[w]) rd_mux = bank_rd[w];
    end
  end

  always_comb begin
    rdata_n = rdata_q;
    if (rd_acc) rdata_n = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/dmaport_mem_slave_chk.sv
module dmaport_mem_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_en,
  input logic [1:0]  req_strb,
  input logic        rsp_ready,
  input logic        rsp_err,
  input logic [15:0] rsp_rdata
);

  // R2: ready lasts exactly one cycle
  a_r2_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  // R2: ready only follows a request seen on the previous edge
  a_r2_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> $past(req_en));

  // R8: error response only together with ready
  a_r8_err_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_ready);

  // R8: missed read returns zero
  a_r8_miss_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && rsp_err && req_en && req_strb == 2'b00) |=> (rsp_rdata == 16'h0000));

  // R6: read data held unless a read is accepted
  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ready && req_en && req_strb == 2'b00) |=> $stable(rsp_rdata));

endmodule

bind dmaport_mem_slave dmaport_mem_slave_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_en    (req_en),
  .req_strb  (req_strb),
  .rsp_ready (rsp_ready),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/dmaport_mem_slave_tb.sv
`timescale 1ns/100ps
module dmaport_mem_slave_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_en;
  logic [14:0] req_waddr;
  logic [1:0]  req_strb;
  logic [15:0] req_wdata;
  logic [1:0]  wait_cnt;
  logic        rsp_ready;
  logic        rsp_err;
  logic [15:0] rsp_rdata;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  dmaport_mem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_waddr(req_waddr),
    .req_strb(req_strb), .req_wdata(req_wdata), .wait_cnt(wait_cnt),
    .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // fields: wait[52:51] strb[50:49] addr[48:33] wdata[32:17] err[16] rdata[15:0]
  localparam int NV = 24;
  localparam logic [52:0] VEC [NV] = '{
    {2'd0, 2'b11, 16'hFE00, 16'h1234, 1'b0, 16'h0000},
    {2'd1, 2'b11, 16'h0200, 16'hABCD, 1'b0, 16'h0000},
    {2'd2, 2'b00, 16'hFE00, 16'h0000, 1'b0, 16'h1234},
    {2'd3, 2'b00, 16'h0200, 16'h0000, 1'b0, 16'hABCD},
    {2'd0, 2'b10, 16'hFE01, 16'h5600, 1'b0, 16'h0000},
    {2'd1, 2'b01, 16'h0200, 16'h0011, 1'b0, 16'h0000},
    {2'd0, 2'b00, 16'hFE00, 16'h0000, 1'b0, 16'h5634},
    {2'd2, 2'b00, 16'h0200, 16'h0000, 1'b0, 16'hAB11},
    {2'd0, 2'b11, 16'hFEFE, 16'hBEEF, 1'b0, 16'h0000},
    {2'd1, 2'b11, 16'h02FE, 16'hCAFE, 1'b0, 16'h0000},
    {2'd3, 2'b00, 16'hFEFE, 16'h0000, 1'b0, 16'hBEEF},
    {2'd0, 2'b00, 16'h02FE, 16'h0000, 1'b0, 16'hCAFE},
    {2'd1, 2'b11, 16'hFF00, 16'hFFFF, 1'b1, 16'h0000},
    {2'd0, 2'b00, 16'hFE00, 16'h0000, 1'b0, 16'h5634},
    {2'd2, 2'b11, 16'hFDFE, 16'h0F0F, 1'b1, 16'h0000},
    {2'd0, 2'b00, 16'hFEFE, 16'h0000, 1'b0, 16'hBEEF},
    {2'd0, 2'b11, 16'h0300, 16'h7777, 1'b1, 16'h0000},
    {2'd1, 2'b00, 16'h0200, 16'h0000, 1'b0, 16'hAB11},
    {2'd0, 2'b00, 16'h0300, 16'h0000, 1'b1, 16'h0000},
    {2'd3, 2'b00, 16'h0100, 16'h0000, 1'b1, 16'h0000},
    {2'd0, 2'b11, 16'hFE02, 16'h1111, 1'b0, 16'h0000},
    {2'd0, 2'b11, 16'h0202, 16'h2222, 1'b0, 16'h0000},
    {2'd1, 2'b00, 16'hFE02, 16'h0000, 1'b0, 16'h1111},
    {2'd2, 2'b00, 16'h0202, 16'h0000, 1'b0, 16'h2222}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string data_tag(input int i);
    if (i == 6 || i == 7)   return "R4 R5";
    if (i >= 20)            return "R10";
    if (i >= 8 && i <= 15)  return "R7";
    if (VEC[i][16])         return "R8";
    return "R3";
  endfunction

  task automatic do_acc(input logic [1:0] w, input logic [1:0] s,
                        input logic [15:0] a, input logic [15:0] d,
                        output logic e, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_en = 1'b1; req_waddr = a[15:1]; req_strb = s;
    req_wdata = d; wait_cnt = w;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rsp_ready && lat < 16);
    e = rsp_err;
    @(negedge clk);
    req_en = 1'b0; req_strb = 2'b00; req_wdata = '0;
    rd = rsp_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic        e;
    logic [15:0] rd, held;
    int          lat;
    rst_n = 1'b0; req_en = 1'b0; req_waddr = '0; req_strb = '0;
    req_wdata = '0; wait_cnt = '0;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", 32'(rsp_ready), 0);
    check("R1", "err in reset", 32'(rsp_err), 0);
    check("R1", "rdata in reset", 32'(rsp_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", 32'(rsp_ready), 0);
    check("R1", "rdata after reset", 32'(rsp_rdata), 0);

    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      v = VEC[i];
      do_acc(v[52:51], v[50:49], v[48:33], v[32:17], e, rd, lat);
      check("R2", $sformatf("latency vec %0d", i), 32'(lat), 32'(v[52:51]) + 1);
      if (v[16]) check("R8", $sformatf("err vec %0d", i), 32'(e), 1);
      else       check("R9", $sformatf("err vec %0d", i), 32'(e), 0);
      if (v[50:49] == 2'b00)
        check(data_tag(i), $sformatf("rdata vec %0d", i), 32'(rd), 32'(v[15:0]));
    end

    // R6: read data held across a write and a missed write
    do_acc(2'd0, 2'b00, 16'hFE02, 16'h0000, e, rd, lat);
    held = rd;
    do_acc(2'd1, 2'b11, 16'hFE02, 16'h9999, e, rd, lat);
    check("R6", "rdata held over write", 32'(rd), 32'(held));
    do_acc(2'd0, 2'b11, 16'h8000, 16'h4444, e, rd, lat);
    check("R6", "rdata held over miss write", 32'(rd), 32'(held));
    do_acc(2'd0, 2'b00, 16'hFE02, 16'h0000, e, rd, lat);
    check("R3", "word rewritten", 32'(rd), 32'h9999);

    // R1: reset during a stretched access
    @(negedge clk);
    req_en = 1'b1; req_waddr = 15'h7F00; req_strb = 2'b00; wait_cnt = 2'd3;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "ready after mid-access reset", 32'(rsp_ready), 0);
    req_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "ready stays low after reset", 32'(rsp_ready), 0);
    check("R1", "rdata cleared by reset", 32'(rsp_rdata), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule